// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset-Selected Read Mode

This block is an 18-bit first-in first-out buffer. Its write port and its read port run on clocks that are unrelated to each other. Pointers move between the two domains as Gray code through two-flop synchronizers. The storage holds 2^ADDR_W words.

One input, `mode_si`, has two jobs. While `rst` is high, its level selects the read behaviour, and that choice holds until the next reset:

- **Standard mode.** Each word leaves only when a read is requested.
- **Fall-through mode.** The oldest word is placed on the output by itself, and a read request retires it.

After reset, `mode_si` becomes the serial data line for the two flag thresholds. It shifts only if serial loading was chosen at reset through `ser_sel`.

Besides the mode-dependent status pair, the block drives three more flags:

- an active-low half-full flag, which only the write side can set and only the read side can clear;
- a programmable almost-empty flag;
- a programmable almost-full flag.

All word counts for these flags are of words held in the storage array. In fall-through mode, the word waiting in the output register is not counted.

Top module: `dfifo_top`

## Requirements
- R1: `mode_si` high while `rst` is high selects fall-through mode, and low selects standard mode. The mode does not change until the next reset, whatever `mode_si` does after reset. After reset `dout` is 0, `hf_n` is 1, `pae` is 1 and `paf` is 0.
- R2: In standard mode, `out_flag` is 1 exactly when the array holds no word. A word is read only on a `rclk` edge with `ren` high and `out_flag` low, and it appears on `dout` at that edge. At all other times `dout` and the read position hold, including when `ren` is high while empty.
- R3: In fall-through mode, a word written into an empty FIFO appears on `dout` at the third `rclk` rising edge after its write edge, with `ren` low. `out_flag` is 1 while `dout` holds an unread word. A `rclk` edge with `ren` high retires that word and loads the next one, if present, at the same edge. Without `ren`, `dout` holds.
- R4: `in_flag` reports fullness: in standard mode 1 means full, and in fall-through mode 1 means space is free (input ready). A write while full is discarded, and the stored data and order are unchanged.
- R5: After the read that frees space in a full FIFO, `in_flag` still shows full after the first `wclk` rising edge and shows space after the second.
- R6: `hf_n` goes low once the array holds more than 2^(ADDR_W-1) words. It returns high once the read side sees that many or fewer. Only the write clock drives it low and only the read clock drives it high.
- R7: `pae` is 1 when the stored count is at most the almost-empty offset. `paf` is 1 when the free entry count is at most the almost-full offset. Both offsets are 127 after reset.
- R8: If `ser_sel` was high at reset, each `wclk` edge with `ser_en` high shifts `mode_si` into the offsets. The almost-empty offset is filled first, then the almost-full offset, each LSB first. Bits beyond 2*OFS_W are ignored. If `ser_sel` was low at reset, `ser_en` has no effect.
- R9: With reads and writes interleaved freely in both domains, every word is read exactly once, in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst | input | 1 | Synchronous active-high master reset, held across edges of both clocks |
| mode_si | input | 1 | Read-mode select during reset; serial offset data afterwards |
| ser_sel | input | 1 | Sampled during reset: 1 enables serial offset loading |
| ser_en | input | 1 | Shift one offset bit on this `wclk` edge |
| wen | input | 1 | Write request |
| din | input | DATA_W | Write data |
| ren | input | 1 | Read request |
| dout | output | DATA_W | Read data |
| in_flag | output | 1 | Standard: full; fall-through: input ready |
| out_flag | output | 1 | Standard: empty; fall-through: output ready |
| hf_n | output | 1 | Half-full, active low |
| pae | output | 1 | Almost-empty |
| paf | output | 1 | Almost-full |

## Verification
A write can arrive on the same cycle as a read that frees the only slot, and a fall-through preload can coincide with the retirement of the word on the output.

A random phase provokes both. It first drives writes at a high rate against slow reads, so the FIFO sits at full while reads trickle out. It then reverses the rates, so that retirement and preload meet at empty.

Every word taken on either side is judged against a queue of accepted writes. A write counts as accepted only if the full indication sampled before its edge was clear. A lost, duplicated or reordered word therefore shows up as a data mismatch.

// File: rtl/dfifo_pkg.sv
`timescale 1ns/1ps
package dfifo_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic full;
        logic afull;
    } wr_stat_t;

    typedef struct packed {
        logic empty;
        logic aempty;
        logic ovalid;
    } rd_stat_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dfifo_sync.sv
`timescale 1ns/1ps
module dfifo_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dfifo_wr_side.sv
`timescale 1ns/1ps
module dfifo_wr_side
    import dfifo_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int OFS_W   = 8,
    parameter int DEF_OFS = 127
) (
    input  logic              wclk,
    input  logic              rst,
    input  logic              mode_si,
    input  logic              ser_sel,
    input  logic              ser_en,
    input  logic              wen,
    input  logic [ADDR_W:0]   rgray_s,
    input  logic              rtog_s,
    output logic [ADDR_W:0]   wptr,
    output logic [ADDR_W:0]   wgray,
    output logic              wr_go,
    output wr_stat_t          stat,
    output rd_mode_e          mode_w,
    output logic [OFS_W-1:0]  ofs_ae,
    output logic [OFS_W-1:0]  ofs_af,
    output logic              wtog
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DEPTH / 2;
    localparam int SBITS = 2 * OFS_W;
    localparam int CW    = $clog2(SBITS + 1);

    logic [PW-1:0]    rptr_s;
    logic [PW-1:0]    wcount;
    logic [PW-1:0]    wfree;
    logic [SBITS-1:0] ofs_sr;
    logic [CW-1:0]    scnt;
    logic             ser_on;

    always_comb begin
        rptr_s     = PW'(gray2bin(32'(rgray_s)));
        wcount     = wptr - rptr_s;
        wfree      = PW'(DEPTH) - wcount;
        stat.full  = (wcount == PW'(DEPTH));
        stat.afull = (int'(wfree) <= int'(ofs_af));
        wr_go      = wen & ~stat.full;
    end

    assign ofs_ae = ofs_sr[OFS_W-1:0];
    assign ofs_af = ofs_sr[SBITS-1:OFS_W];

    always_ff @(posedge wclk) begin
        if (rst) begin
            wptr   <= '0;
            wgray  <= '0;
            wtog   <= 1'b0;
            scnt   <= '0;
            mode_w <= rd_mode_e'(mode_si);
            ser_on <= ser_sel;
            ofs_sr <= {OFS_W'(DEF_OFS), OFS_W'(DEF_OFS)};
        end else begin
            if (wr_go) begin
                wptr  <= wptr + 1'b1;
                wgray <= PW'(bin2gray(32'(wptr + 1'b1)));
            end
            if (ser_on && ser_en && (scnt != CW'(SBITS))) begin
                ofs_sr <= {mode_si, ofs_sr[SBITS-1:1]};
                scnt   <= scnt + 1'b1;
            end
            if ((wcount > PW'(HALF)) && (wtog == rtog_s)) begin
                wtog <= ~wtog;
            end
        end
    end
endmodule

// File: rtl/dfifo_rd_side.sv
`timescale 1ns/1ps
module dfifo_rd_side
    import dfifo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18,
    parameter int OFS_W  = 8
) (
    input  logic              rclk,
    input  logic              rst,
    input  logic              mode_si,
    input  logic              ren,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic              wtog_s,
    input  logic [DATA_W-1:0] mem_q,
    input  logic [OFS_W-1:0]  ofs_ae,
    output logic [ADDR_W:0]   rptr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] dout,
    output rd_stat_t          stat,
    output rd_mode_e          mode_r,
    output logic              rtog
);
    localparam int PW   = ADDR_W + 1;
    localparam int HALF = (1 << ADDR_W) / 2;

    logic [PW-1:0] wptr_s;
    logic [PW-1:0] rcount;
    logic          take;

    always_comb begin
        wptr_s      = PW'(gray2bin(32'(wgray_s)));
        rcount      = wptr_s - rptr;
        stat.empty  = (rcount == '0);
        stat.aempty = (int'(rcount) <= int'(ofs_ae));
        if (mode_r == MODE_FWFT) begin
            take = ~stat.empty & (~stat.ovalid | ren);
        end else begin
            take = ~stat.empty & ren;
        end
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            rptr        <= '0;
            rgray       <= '0;
            dout        <= '0;
            rtog        <= 1'b0;
            stat.ovalid <= 1'b0;
            mode_r      <= rd_mode_e'(mode_si);
        end else begin
            if (take) begin
                dout  <= mem_q;
                rptr  <= rptr + 1'b1;
                rgray <= PW'(bin2gray(32'(rptr + 1'b1)));
            end
            if (mode_r == MODE_FWFT) begin
                if (take) begin
                    stat.ovalid <= 1'b1;
                end else if (ren) begin
                    stat.ovalid <= 1'b0;
                end
            end
            if ((rcount <= PW'(HALF)) && (rtog != wtog_s)) begin
                rtog <= ~rtog;
            end
        end
    end
endmodule

// File: rtl/dfifo_top.sv
`timescale 1ns/1ps
module dfifo_top
    import dfifo_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int ADDR_W  = 8,
    parameter int OFS_W   = 8,
    parameter int DEF_OFS = 127
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              mode_si,
    input  logic              ser_sel,
    input  logic              ser_en,
    input  logic              wen,
    input  logic [DATA_W-1:0] din,
    input  logic              ren,
    output logic [DATA_W-1:0] dout,
    output logic              in_flag,
    output logic              out_flag,
    output logic              hf_n,
    output logic              pae,
    output logic              paf
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    logic [PW-1:0]    wptr, wgray, rptr, rgray;
    logic [PW-1:0]    wgray_s, rgray_s;
    logic             wtog, rtog, wtog_s, rtog_s;
    logic             wr_go, wfull;
    logic [OFS_W-1:0] ofs_ae, ofs_af;
    wr_stat_t         wstat;
    rd_stat_t         rstat;
    rd_mode_e         mode_w, mode_r;

    dfifo_sync #(.W(PW + 1)) u_sync_w2r (
        .clk (rclk),
        .rst (rst),
        .d   ({wgray, wtog}),
        .q   ({wgray_s, wtog_s})
    );

    dfifo_sync #(.W(PW + 1)) u_sync_r2w (
        .clk (wclk),
        .rst (rst),
        .d   ({rgray, rtog}),
        .q   ({rgray_s, rtog_s})
    );

    dfifo_wr_side #(
        .ADDR_W  (ADDR_W),
        .OFS_W   (OFS_W),
        .DEF_OFS (DEF_OFS)
    ) u_wr (
        .wclk    (wclk),
        .rst     (rst),
        .mode_si (mode_si),
        .ser_sel (ser_sel),
        .ser_en  (ser_en),
        .wen     (wen),
        .rgray_s (rgray_s),
        .rtog_s  (rtog_s),
        .wptr    (wptr),
        .wgray   (wgray),
        .wr_go   (wr_go),
        .stat    (wstat),
        .mode_w  (mode_w),
        .ofs_ae  (ofs_ae),
        .ofs_af  (ofs_af),
        .wtog    (wtog)
    );

    dfifo_rd_side #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_rd (
        .rclk    (rclk),
        .rst     (rst),
        .mode_si (mode_si),
        .ren     (ren),
        .wgray_s (wgray_s),
        .wtog_s  (wtog_s),
        .mem_q   (mem[rptr[ADDR_W-1:0]]),
        .ofs_ae  (ofs_ae),
        .rptr    (rptr),
        .rgray   (rgray),
        .dout    (dout),
        .stat    (rstat),
        .mode_r  (mode_r),
        .rtog    (rtog)
    );

    always_ff @(posedge wclk) begin
        if (!rst && wr_go) begin
            mem[wptr[ADDR_W-1:0]] <= din;
        end
    end

    assign wfull    = wstat.full;
    assign in_flag  = (mode_w == MODE_FWFT) ? ~wstat.full : wstat.full;
    assign out_flag = (mode_r == MODE_FWFT) ? rstat.ovalid : rstat.empty;
    assign hf_n     = ~(wtog ^ rtog);
    assign pae      = rstat.aempty;
    assign paf      = wstat.afull;
endmodule

// File: rtl/dfifo_chk.sv
`timescale 1ns/1ps
module dfifo_chk #(
    parameter int PW = 9,
    parameter int DW = 18,
    parameter int OW = 8
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst,
    input logic          wen,
    input logic          ren,
    input logic          ser_en,
    input logic          wfull,
    input logic          out_flag,
    input logic          mode_r,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr,
    input logic [DW-1:0] dout,
    input logic [OW-1:0] ofs_ae,
    input logic [OW-1:0] ofs_af
);
    // R4
    no_overflow_chk: assert property (@(posedge wclk) disable iff (rst)
        (wfull && wen) |=> $stable(wptr));

    // R2
    no_underflow_chk: assert property (@(posedge rclk) disable iff (rst)
        (!mode_r && out_flag) |=> $stable(rptr));

    // R2
    std_hold_chk: assert property (@(posedge rclk) disable iff (rst)
        (!mode_r && !ren) |=> ($stable(dout) && $stable(rptr)));

    // R3
    fwft_hold_chk: assert property (@(posedge rclk) disable iff (rst)
        (mode_r && out_flag && !ren) |=> $stable(dout));

    // R1
    mode_lock_chk: assert property (@(posedge rclk) disable iff (rst)
        $stable(mode_r));

    // R8
    ofs_lock_chk: assert property (@(posedge wclk) disable iff (rst)
        !ser_en |=> $stable({ofs_ae, ofs_af}));
endmodule

bind dfifo_top dfifo_chk #(
    .PW (ADDR_W + 1),
    .DW (DATA_W),
    .OW (OFS_W)
) u_chk (
    .wclk     (wclk),
    .rclk     (rclk),
    .rst      (rst),
    .wen      (wen),
    .ren      (ren),
    .ser_en   (ser_en),
    .wfull    (wfull),
    .out_flag (out_flag),
    .mode_r   (mode_r),
    .wptr     (wptr),
    .rptr     (rptr),
    .dout     (dout),
    .ofs_ae   (ofs_ae),
    .ofs_af   (ofs_af)
);

// File: tb/sim_dfifo_top.sv
`timescale 1ns/1ps
module sim_dfifo_top;
    localparam int DW    = 18;
    localparam int DEPTH = 256;

    logic wclk = 1'b0;
    logic rclk = 1'b0;
    always #2   wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    logic          rst = 1'b1, mode_si = 1'b0, ser_sel = 1'b0, ser_en = 1'b0;
    logic          wen = 1'b0, ren = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          in_flag, out_flag, hf_n, pae, paf;

    int            checks = 0;
    int            errors = 0;
    bit            cur_fwft = 1'b0;
    bit            wdone = 1'b0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] tmp;

    dfifo_top u0 (
        .wclk(wclk), .rclk(rclk), .rst(rst), .mode_si(mode_si),
        .ser_sel(ser_sel), .ser_en(ser_en), .wen(wen), .din(din),
        .ren(ren), .dout(dout), .in_flag(in_flag), .out_flag(out_flag),
        .hf_n(hf_n), .pae(pae), .paf(paf)
    );

    function automatic bit is_full(input bit fwft, input logic inf);
        return fwft ? !inf : inf;
    endfunction

    function automatic bit exp_pae(input int cnt, input int ofs);
        return cnt <= ofs;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit mode, input bit sel);
        rst = 1'b1; mode_si = mode; ser_sel = sel;
        wen = 0; ren = 0; ser_en = 0;
        q.delete();
        cur_fwft = mode;
        repeat (6) @(negedge rclk);
        @(negedge wclk);
        rst = 1'b0;
        repeat (3) @(negedge rclk);
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
    endtask

    task automatic wr_word(input logic [DW-1:0] d);
        @(negedge wclk);
        wen = 1'b1; din = d;
        if (!is_full(cur_fwft, in_flag)) q.push_back(d);
    endtask

    task automatic wr_idle();
        @(negedge wclk);
        wen = 1'b0;
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            ser_en = 1'b1; mode_si = v[i];
        end
        @(negedge wclk);
        ser_en = 1'b0;
    endtask

    task automatic rd_std(input string req);
        @(negedge rclk);
        while (out_flag) @(negedge rclk);
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
        tmp = q.pop_front();
        chk(dout == tmp, req, 32'(dout), 32'(tmp));
    endtask

    task automatic rd_fwft(input string req);
        @(negedge rclk);
        while (!out_flag) @(negedge rclk);
        tmp = q.pop_front();
        chk(dout == tmp, req, 32'(dout), 32'(tmp));
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // ---------------- standard mode, serial loading on ----------------
        do_reset(1'b0, 1'b1);
        chk(out_flag == 1, "R1 std empty after reset", 32'(out_flag), 1);
        chk(in_flag == 0, "R1 std not full after reset", 32'(in_flag), 0);
        chk(dout == 0, "R1 dout reset", 32'(dout), 0);
        chk(hf_n == 1, "R1 hf_n reset", 32'(hf_n), 1);
        chk(pae == exp_pae(0, 127), "R7 pae reset", 32'(pae), 1);
        chk(paf == 0, "R7 paf reset", 32'(paf), 0);

        // almost-empty = 5, almost-full = 10, then 3 surplus ones ignored (R8)
        shift_bits({16'd0, 8'd10, 8'd5}, 16);
        shift_bits(32'h7, 3);

        for (int i = 0; i < 5; i++) wr_word(18'(i + 32'h100));
        wr_idle(); settle();
        chk(pae == exp_pae(5, 5), "R8 ae offset loaded 5 words", 32'(pae), 1);
        chk(out_flag == 0, "R2 not empty", 32'(out_flag), 0);
        chk(dout == 0, "R2 no read without ren", 32'(dout), 0);
        wr_word(18'h2aaaa); wr_idle(); settle();
        chk(pae == exp_pae(6, 5), "R8 ae offset 6 words", 32'(pae), 0);
        rd_std("R2 first std read");

        for (int i = 0; i < DEPTH - 5; i++) wr_word(18'($urandom));
        wr_idle(); settle();
        chk(in_flag == 1, "R4 std full", 32'(in_flag), 1);
        chk(paf == 1, "R8 af offset at full", 32'(paf), 1);
        chk(hf_n == 0, "R6 hf_n low when full", 32'(hf_n), 0);
        wr_word(18'h3ffff); wr_idle(); settle();
        chk(q.size() == DEPTH, "R4 bench model full", 32'(q.size()), DEPTH);

        // R5 release timing
        @(negedge rclk);
        ren = 1'b1;
        tmp = q.pop_front();
        @(posedge rclk);
        fork
            begin @(negedge rclk); ren = 1'b0; end
        join_none
        @(posedge wclk); @(negedge wclk);
        chk(in_flag == 1, "R5 still full after 1 wclk", 32'(in_flag), 1);
        @(posedge wclk); @(negedge wclk);
        chk(in_flag == 0, "R5 released after 2 wclk", 32'(in_flag), 0);
        settle();
        chk(dout == tmp, "R4 read under full", 32'(dout), 32'(tmp));

        while (q.size() > 0) rd_std("R4 drain order, dropped full write");
        settle();
        chk(out_flag == 1, "R2 empty after drain", 32'(out_flag), 1);
        chk(hf_n == 1, "R6 hf_n released", 32'(hf_n), 1);
        chk(pae == 1, "R7 pae after drain", 32'(pae), 1);

        tmp = dout;
        @(negedge rclk); ren = 1'b1;
        @(negedge rclk); ren = 1'b0;
        chk(dout == tmp, "R2 ren on empty ignored", 32'(dout), 32'(tmp));
        wr_word(18'h01234); wr_idle(); settle();
        rd_std("R2 pointer unchanged by empty read");

        // ---------------- fall-through mode, serial loading off ----------------
        do_reset(1'b1, 1'b0);
        chk(in_flag == 1, "R1 fwft input ready after reset", 32'(in_flag), 1);
        chk(out_flag == 0, "R1 fwft output not ready", 32'(out_flag), 0);
        shift_bits(32'h0, 16);

        @(negedge wclk);
        wen = 1'b1; din = 18'h15a5a; q.push_back(18'h15a5a);
        @(posedge wclk);
        fork
            begin @(negedge wclk); wen = 1'b0; end
        join_none
        for (int k = 1; k <= 3; k++) begin
            @(posedge rclk); @(negedge rclk);
            chk(out_flag == (k == 3), "R3 fall-through latency", 32'(out_flag), 32'(k == 3));
        end
        chk(dout == 18'h15a5a, "R3 first word on dout", 32'(dout), 32'h15a5a);

        for (int i = 0; i < 3; i++) wr_word(18'(32'h200 + i));
        wr_idle(); settle();
        chk(pae == exp_pae(3, 127), "R8 ignored when ser_sel low; R7 default", 32'(pae), 1);
        chk(dout == 18'h15a5a, "R3 dout held without ren", 32'(dout), 32'h15a5a);
        chk(out_flag == 1, "R1 mode kept after pin toggles", 32'(out_flag), 1);
        for (int i = 0; i < 4; i++) rd_fwft("R3 fwft read order");
        settle();
        chk(out_flag == 0, "R3 output not ready when drained", 32'(out_flag), 0);

        // random concurrent traffic
        fork
            begin
                for (int i = 0; i < 3000; i++) begin
                    @(negedge wclk);
                    wen = (($urandom % 100) < ((i < 1500) ? 85 : 25));
                    din = 18'($urandom);
                    if (wen && !is_full(cur_fwft, in_flag)) q.push_back(din);
                end
                @(negedge wclk);
                wen = 1'b0;
                wdone = 1'b1;
            end
            begin
                int n = 0;
                while (!(wdone && q.size() == 0)) begin
                    @(negedge rclk);
                    n++;
                    if (out_flag && (($urandom % 100) < (wdone ? 100 : ((n < 850) ? 30 : 90)))) begin
                        chk(dout == q[0], "R9 random order", 32'(dout), 32'(q[0]));
                        void'(q.pop_front());
                        ren = 1'b1;
                    end else begin
                        ren = !out_flag && (($urandom % 4) == 0);
                    end
                end
                @(negedge rclk);
                ren = 1'b0;
            end
        join
        settle();
        chk(out_flag == 0, "R9 all words consumed", 32'(out_flag), 0);
        chk(hf_n == 1, "R6 hf_n after random", 32'(hf_n), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule